// File: doc/BRIEF.md
# Programmable Reference Divider with Output Select

The block divides a reference clock down to a comparison rate for a phase detector. The reference arrives as a single-cycle clock enable, `ref_tick`, in the system clock domain. A counter counts these ticks and emits one comparison pulse each time a full ratio has elapsed.

The ratio comes from a 5-bit code. The upper two bits pick a base factor of 2, 5, 6 or 7, and the lower three bits pick a power-of-two multiplier. Three codes are illegal, so 29 ratios from 2 to 448 are usable. A load strobe captures the code together with two output-control bits, the enable and the source select. These bits route either the reference ticks or the comparison pulses to a shared output pin, or leave that pin undriven.

The interface has no streamed data, so every pin is a plain control or status signal with no back-pressure. A new ratio is held pending and only replaces the running ratio at a terminal count. An illegal code is refused and reported.

Top module: `refdiv_top`

## Requirements
- R1: With code bits [4:3] = 00, code bits [2:0] = n (0..7) select a ratio of 2·2^n, which gives 2 up to 256.
- R2: With code bits [4:3] = 01, 10 or 11, the base is 5, 6 or 7 respectively. For n = 1..7 the ratio is base·2^(n-1), which gives up to 448.
- R3: Loading one of the illegal codes 01000, 10000 or 11000 sets `code_err` on the next cycle and leaves the running ratio unchanged.
- R4: `comp_pulse` is high for exactly one cycle, one cycle after every ratio-th `ref_tick`, and never in two consecutive cycles.
- R5: A newly loaded legal ratio takes effect only after the comparison period in progress completes with the old ratio, so no shortened period is produced.
- R6: `refout_oe` equals the latched enable bit. When it is 0, `refout_val` is 0. When it is 1 and select = 0, `refout_val` is `ref_tick` delayed by one cycle. When it is 1 and select = 1, `refout_val` follows `comp_pulse`.
- R7: After reset, enable and select are both 1, the ratio is the one given by parameter `RST_CODE` (default 00000, ratio 2), `code_err` is 0, and no pulse is pending.
- R8: Loading a legal code clears `code_err` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference clock enable, one tick per reference period |
| cfg_load | input | 1 | Captures cfg_code, cfg_re and cfg_rs |
| cfg_code | input | 5 | Ratio code: [4:3] base select, [2:0] exponent |
| cfg_re | input | 1 | Output enable bit |
| cfg_rs | input | 1 | Output source select: 0 reference, 1 comparison |
| comp_pulse | output | 1 | Comparison pulse |
| code_err | output | 1 | Last loaded code was illegal |
| refout_val | output | 1 | Value on the shared reference/comparison output |
| refout_oe | output | 1 | Drive enable for the shared output |

## Verification
The bench builds the block with its default parameters. The 3-bit exponent field therefore reaches the full ratio range of 2 to 448, and the default reset code gives a ratio of 2, so the reset behaviour shows up within a few cycles. With `ref_tick` held high continuously, each comparison period in clock cycles equals the ratio. This lets every one of the 32 codes be walked and measured, including the largest ratio and all three illegal codes. Directed tests then check a ratio change made in the middle of a period and each of the three output routings.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned EXP_W     = 3;
  localparam int unsigned CODE_W    = EXP_W + 2;
  localparam int unsigned MAX_RATIO = 7 << ((1 << EXP_W) - 2);
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   bad;
    ratio_t ratio;
  } decode_t;

  // Base factor from the two top code bits, exponent from the rest.
  function automatic decode_t decode_ratio(input logic [CODE_W-1:0] code);
    decode_t          d;
    logic [1:0]       b;
    logic [EXP_W-1:0] e;
    ratio_t           base;
    b = code[CODE_W-1 -: 2];
    e = code[EXP_W-1:0];
    case (b)
      2'd0:    base = ratio_t'(2);
      2'd1:    base = ratio_t'(5);
      2'd2:    base = ratio_t'(6);
      default: base = ratio_t'(7);
    endcase
    d.bad = 1'b0;
    if (b == 2'd0) begin
      d.ratio = base << e;
    end else if (e == '0) begin
      d.bad   = 1'b1;
      d.ratio = base;
    end else begin
      d.ratio = base << (e - 1'b1);
    end
    return d;
  endfunction
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
  import refdiv_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              re_in,
  input  logic              rs_in,
  output ratio_t            pend_ratio,
  output logic              err,
  output logic              re_q,
  output logic              rs_q
);
  localparam decode_t RST_DEC = decode_ratio(RST_CODE);

  decode_t dec;
  always_comb dec = decode_ratio(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ratio <= RST_DEC.ratio;
      err        <= 1'b0;
      re_q       <= 1'b1;
      rs_q       <= 1'b1;
    end else if (load) begin
      re_q <= re_in;
      rs_q <= rs_in;
      err  <= dec.bad;
      if (!dec.bad) pend_ratio <= dec.ratio;
    end
  end
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
#(
  parameter ratio_t RST_RATIO = ratio_t'(2)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  ratio_t pend_ratio,
  output logic   term,
  output logic   tick_q
);
  ratio_t active;
  ratio_t cnt;
  logic   at_end;

  always_comb at_end = (cnt == active - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= RST_RATIO;
      cnt    <= '0;
      term   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick;
      term   <= tick & at_end;
      if (tick) begin
        if (at_end) begin
          cnt    <= '0;
          active <= pend_ratio;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/refdiv_outsel.sv
module refdiv_outsel (
  input  logic re_q,
  input  logic rs_q,
  input  logic ref_q,
  input  logic comp,
  output logic val,
  output logic oe
);
  always_comb begin
    oe  = re_q;
    val = re_q & (rs_q ? comp : ref_q);
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_re,
  input  logic              cfg_rs,
  output logic              comp_pulse,
  output logic              code_err,
  output logic              refout_val,
  output logic              refout_oe
);
  localparam decode_t RST_DEC = decode_ratio(RST_CODE);

  ratio_t pend_ratio;
  logic   re_q, rs_q, ref_q;

  refdiv_cfg #(.RST_CODE(RST_CODE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .code(cfg_code),
    .re_in(cfg_re), .rs_in(cfg_rs), .pend_ratio(pend_ratio),
    .err(code_err), .re_q(re_q), .rs_q(rs_q)
  );

  refdiv_count #(.RST_RATIO(RST_DEC.ratio)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .pend_ratio(pend_ratio),
    .term(comp_pulse), .tick_q(ref_q)
  );

  refdiv_outsel u_out (
    .re_q(re_q), .rs_q(rs_q), .ref_q(ref_q), .comp(comp_pulse),
    .val(refout_val), .oe(refout_oe)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              cfg_load,
  input logic [CODE_W-1:0] cfg_code,
  input logic              cfg_re,
  input logic              comp_pulse,
  input logic              code_err,
  input logic              refout_val,
  input logic              refout_oe,
  input logic              re_q,
  input logic              rs_q
);
  logic               armed;
  logic [RATIO_W:0]   since;
  logic               bad_code;

  always_comb bad_code = (cfg_code[EXP_W-1:0] == '0) && (cfg_code[CODE_W-1 -: 2] != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      since <= '0;
    end else begin
      armed <= 1'b1;
      if (comp_pulse) since <= {{RATIO_W{1'b0}}, ref_tick};
      else if (ref_tick) since <= since + 1'b1;
    end
  end

  p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && bad_code) |=> code_err);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !bad_code) |=> !code_err);

  p_pulse_from_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && comp_pulse) |-> $past(ref_tick));

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    comp_pulse |=> !comp_pulse);

  p_period_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    since <= (RATIO_W+1)'(MAX_RATIO));

  p_oe_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (refout_oe == $past(cfg_re)));

  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !refout_oe |-> !refout_val);

  p_ref_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && re_q && !rs_q) |-> (refout_val == $past(ref_tick)));
endmodule

bind refdiv_top refdiv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_load(cfg_load),
  .cfg_code(cfg_code), .cfg_re(cfg_re), .comp_pulse(comp_pulse),
  .code_err(code_err), .refout_val(refout_val), .refout_oe(refout_oe),
  .re_q(re_q), .rs_q(rs_q)
);

// File: tb/refdiv_top_bench.sv
module refdiv_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       cfg_load = 1'b0;
  logic [4:0] cfg_code = '0;
  logic       cfg_re = 1'b1;
  logic       cfg_rs = 1'b1;
  logic       comp_pulse, code_err, refout_val, refout_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  refdiv_top u_refdiv_top (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_load(cfg_load),
    .cfg_code(cfg_code), .cfg_re(cfg_re), .cfg_rs(cfg_rs),
    .comp_pulse(comp_pulse), .code_err(code_err),
    .refout_val(refout_val), .refout_oe(refout_oe)
  );

  // {illegal, ratio} indexed by code
  localparam logic [9:0] VEC [32] = '{
    {1'b0,9'd2},  {1'b0,9'd4},  {1'b0,9'd8},   {1'b0,9'd16},
    {1'b0,9'd32}, {1'b0,9'd64}, {1'b0,9'd128}, {1'b0,9'd256},
    {1'b1,9'd0},  {1'b0,9'd5},  {1'b0,9'd10},  {1'b0,9'd20},
    {1'b0,9'd40}, {1'b0,9'd80}, {1'b0,9'd160}, {1'b0,9'd320},
    {1'b1,9'd0},  {1'b0,9'd6},  {1'b0,9'd12},  {1'b0,9'd24},
    {1'b0,9'd48}, {1'b0,9'd96}, {1'b0,9'd192}, {1'b0,9'd384},
    {1'b1,9'd0},  {1'b0,9'd7},  {1'b0,9'd14},  {1'b0,9'd28},
    {1'b0,9'd56}, {1'b0,9'd112},{1'b0,9'd224}, {1'b0,9'd448}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] code, input logic re, input logic rs);
    cfg_code = code; cfg_re = re; cfg_rs = rs; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic next_pulse();
    int n = 0;
    @(negedge clk);
    while (!comp_pulse && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic period(output int p);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!comp_pulse && p < 1000);
  endtask

  int last_ratio;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(refout_oe == 1'b1, "R7 oe", refout_oe, 1);
    check(code_err == 1'b0, "R7 err", code_err, 0);
    check(comp_pulse == 1'b0, "R7 pulse", comp_pulse, 0);
    ref_tick = 1'b1;
    next_pulse();
    period(p);
    check(p == 2, "R7 reset ratio", p, 2);
    last_ratio = 2;

    // R1 R2 R3 R8: walk every code
    for (int i = 0; i < 32; i++) begin
      load(5'(i), 1'b1, 1'b1);
      if (VEC[i][9]) begin
        check(code_err == 1'b1, "R3 err set", code_err, 1);
        next_pulse(); next_pulse();
        period(p);
        check(p == last_ratio, "R3 ratio held", p, last_ratio);
      end else begin
        check(code_err == 1'b0, "R8 err clear", code_err, 0);
        next_pulse(); next_pulse();
        period(p);
        check(p == int'(VEC[i][8:0]), i < 8 ? "R1 ratio" : "R2 ratio", p, int'(VEC[i][8:0]));
        last_ratio = int'(VEC[i][8:0]);
      end
    end

    // R5: change mid-period, 8 -> 2
    load(5'b00010, 1'b1, 1'b1);
    next_pulse(); next_pulse();
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    load(5'b00000, 1'b1, 1'b1);
    n++;
    while (!comp_pulse && n < 1000) begin @(negedge clk); n++; end
    check(n == 8, "R5 old period kept", n, 8);
    period(p);
    check(p == 2, "R5 new period", p, 2);

    // R4: one-cycle pulse with ratio 5 and gapped ticks
    load(5'b01001, 1'b1, 1'b1);
    next_pulse(); next_pulse();
    ref_tick = 1'b0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      ref_tick = (k % 2 == 0);
      @(negedge clk);
      if (comp_pulse) n++;
    end
    check(n == 4, "R4 pulses per 20 ticks", n, 4);

    // R6: disabled output
    load(5'b01001, 1'b0, 1'b1);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      if (refout_oe || refout_val) n++;
    end
    check(n == 0, "R6 off", n, 0);

    // R6: reference routed
    load(5'b01001, 1'b1, 1'b0);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      ref_tick = (k % 3 != 0);
      @(negedge clk);
      if (refout_val != ref_tick || !refout_oe) n++;
    end
    check(n == 0, "R6 ref route", n, 0);

    // R6: comparison routed
    load(5'b01001, 1'b1, 1'b1);
    n = 0;
    p = 0;
    for (int k = 0; k < 20; k++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      if (refout_val != comp_pulse) n++;
      if (refout_val) p++;
    end
    check(n == 0 && p == 4, "R6 comp route", p, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule